// File: doc/BRIEF.md
# Programmable Reference Clock Divider

This block slows a reference clock by an integer ratio chosen from an 8-bit programming code. It sits between a reference oscillator and a phase-frequency detector. It delivers two outputs. The first is a divided clock. The second is a strobe, one reference cycle wide, that marks the start of every divided period. Any ratio from 1 up to 256 can be reached. A code of zero is not illegal: it stands for the largest ratio, 256.

The ratio in force is held in a register. That register takes a new value from the code input only at a period boundary, so a code that changes mid-period never produces a short or glitched period. Reset asserts asynchronously and releases through a small synchronizer. After release the block loads the code once and then runs a complete first period before the strobe and the divided clock rise for the first time. At ratio 1 the strobe stays high continuously and the divided clock is the reference clock itself.

Top module: `refdiv_top`

## Requirements
- R1: While rst_n is low, tc_pulse and div_clk are both 0, and they drop at once when rst_n falls, with no clock edge needed.
- R2: After rst_n rises, the first high sample of tc_pulse appears on rising reference edge M+3, counted from the release. The count is two synchronizer edges, one load edge and then M edges, where M is the ratio selected by mod_code.
- R3: For mod_code values 1 to 255, consecutive tc_pulse assertions are exactly mod_code reference cycles apart.
- R4: A mod_code of 0 (all bits clear) selects a ratio of 256, so tc_pulse assertions are 256 reference cycles apart.
- R5: For ratios of 2 or more, tc_pulse is high for exactly one reference cycle per period.
- R6: For ratios of 2 or more, div_clk is high for floor(M/2) reference cycles and low for the remaining ceil(M/2) cycles of each period. Its rising edge follows the same reference edge that raises tc_pulse.
- R7: At ratio 1, tc_pulse stays high on every cycle and div_clk follows clk_ref: high in the high phase of clk_ref and low in the low phase.
- R8: A change of mod_code in the middle of a period does not alter that period. The new ratio applies from the period that starts at the next tc_pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mod_code | input | 8 | Ratio code: 1..255 give that ratio, 0 gives 256 |
| div_clk | output | 1 | Divided clock |
| tc_pulse | output | 1 | Terminal-count strobe, one reference cycle per divided period |

## Verification
Most faults in the internal state show up at the ports within one divided period. A wrong count, a wrong decode of the code, or a ratio register that is reloaded at the wrong time changes the spacing of tc_pulse on the very next period. A miscounted half point changes the duty cycle of div_clk within that same period. A fault in the synchronizer or the load flag changes the latency of the first strobe after reset. A failure to hold the ratio register shows up only when mod_code moves during a period, so that case is driven on purpose and the next two periods are measured.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  // Map a programming code onto a ratio; an all-zero code means 2**w.
  function automatic int unsigned rd_ratio_of(input int unsigned code,
                                              input int unsigned w);
    if (code == 0) return (32'd1 << w);
    return code;
  endfunction

endpackage

// File: rtl/refdiv_rst_sync.sv
module refdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/refdiv_ratio_reg.sv
module refdiv_ratio_reg
  import refdiv_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  localparam int unsigned RAT_W = CODE_W + 1
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              load_en,
  input  logic [CODE_W-1:0] code,
  output logic [RAT_W-1:0]  ratio_q,
  output logic [RAT_W-1:0]  ratio_d
);
  logic [RAT_W-1:0] decoded;

  always_comb begin
    decoded = RAT_W'(rd_ratio_of(32'(code), CODE_W));
    ratio_d = load_en ? decoded : ratio_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) ratio_q <= RAT_W'(32'd1 << CODE_W);
    else         ratio_q <= ratio_d;
  end

  // R4: the register never holds zero, the widest ratio included
  a_r4_ratio_nonzero: assert property (@(posedge clk) disable iff (!srst_n)
    ratio_q != '0);
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int unsigned RAT_W = 9
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic [RAT_W-1:0] ratio_q,
  output logic             run_q,
  output logic [RAT_W-1:0] cnt_q,
  output logic [RAT_W-1:0] cnt_d,
  output logic             wrap
);
  logic run_d;

  always_comb begin
    wrap  = run_q && (cnt_q == (ratio_q - RAT_W'(1)));
    run_d = 1'b1;
    if (!run_q || wrap) cnt_d = '0;
    else                cnt_d = cnt_q + RAT_W'(1);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  // R3: the count stays inside the ratio in force
  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!srst_n)
    run_q |-> (cnt_q < ratio_q));
endmodule

// File: rtl/refdiv_shaper.sv
module refdiv_shaper #(
  parameter int unsigned RAT_W = 9
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             wrap,
  input  logic [RAT_W-1:0] cnt_d,
  input  logic [RAT_W-1:0] ratio_d,
  output logic             tc_q,
  output logic             div_q,
  output logic             byp_q
);
  logic             primed_q, primed_d;
  logic             tc_d, div_d, byp_d;
  logic [RAT_W-1:0] half;

  always_comb begin
    primed_d = primed_q | wrap;
    half     = ratio_d >> 1;
    tc_d     = wrap;
    div_d    = primed_d && (cnt_d < half);
    byp_d    = primed_d && (ratio_d == RAT_W'(1));
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      primed_q <= 1'b0;
      tc_q     <= 1'b0;
      div_q    <= 1'b0;
      byp_q    <= 1'b0;
    end else begin
      primed_q <= primed_d;
      tc_q     <= tc_d;
      div_q    <= div_d;
      byp_q    <= byp_d;
    end
  end

  // R6: a rising divided clock always comes with the strobe
  a_r6_rise_with_tc: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(div_q) |-> tc_q);
  // R7: bypass is only active while the strobe is held
  a_r7_bypass_tc: assert property (@(posedge clk) disable iff (!srst_n)
    byp_q |-> tc_q);
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top #(
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] mod_code,
  output logic              div_clk,
  output logic              tc_pulse
);
  localparam int unsigned RAT_W = CODE_W + 1;

  logic             srst_n;
  logic             run_q, wrap, load_en;
  logic [RAT_W-1:0] ratio_q, ratio_d, cnt_q, cnt_d;
  logic             tc_q, div_q, byp_q;

  refdiv_rst_sync #(.STAGES(RST_STAGES)) u_sync (
    .clk(clk_ref), .rst_n(rst_n), .srst_n(srst_n)
  );

  assign load_en = !run_q || wrap;

  refdiv_ratio_reg #(.CODE_W(CODE_W)) u_ratio (
    .clk(clk_ref), .srst_n(srst_n), .load_en(load_en), .code(mod_code),
    .ratio_q(ratio_q), .ratio_d(ratio_d)
  );

  refdiv_counter #(.RAT_W(RAT_W)) u_cnt (
    .clk(clk_ref), .srst_n(srst_n), .ratio_q(ratio_q), .run_q(run_q),
    .cnt_q(cnt_q), .cnt_d(cnt_d), .wrap(wrap)
  );

  refdiv_shaper #(.RAT_W(RAT_W)) u_shape (
    .clk(clk_ref), .srst_n(srst_n), .wrap(wrap), .cnt_d(cnt_d),
    .ratio_d(ratio_d), .tc_q(tc_q), .div_q(div_q), .byp_q(byp_q)
  );

  assign tc_pulse = tc_q;
  assign div_clk  = byp_q ? clk_ref : div_q;

  // R5: strobe is single-cycle whenever the new ratio exceeds one
  a_r5_tc_one_cycle: assert property (@(posedge clk_ref) disable iff (!srst_n)
    (tc_q && ratio_q != RAT_W'(1)) |=> !tc_q);
  // R8: ratio register moves only at a period boundary or the load edge
  a_r8_ratio_hold: assert property (@(posedge clk_ref) disable iff (!srst_n)
    (run_q && !wrap) |=> $stable(ratio_q));
  // R1: outputs quiet while the internal reset is held
  a_r1_quiet_in_reset: assert property (@(posedge clk_ref)
    !srst_n |-> (!tc_q && !div_q));
endmodule

// File: tb/refdiv_top_tb_top.sv
module refdiv_top_tb_top;
  logic       clk_ref = 1'b0;
  logic       rst_n;
  logic [7:0] mod_code;
  logic       div_clk, tc_pulse;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk_ref = ~clk_ref;

  refdiv_top dut_i (
    .clk_ref(clk_ref), .rst_n(rst_n), .mod_code(mod_code),
    .div_clk(div_clk), .tc_pulse(tc_pulse)
  );

  localparam int NV = 14;
  localparam int V_CODE [NV] = '{2, 3, 4, 5, 7, 8, 10, 16, 37, 100, 128, 200, 255, 0};
  localparam int V_PER  [NV] = '{2, 3, 4, 5, 7, 8, 10, 16, 37, 100, 128, 200, 255, 256};
  localparam int V_HI   [NV] = '{1, 1, 2, 2, 3, 4, 5, 8, 18, 50, 64, 100, 127, 128};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // reset with a given code, check quiet outputs, return edges to first strobe
  task automatic reset_and_latency(input int code, output int n);
    @(negedge clk_ref);
    rst_n = 1'b0;
    mod_code = 8'(code);
    #1;
    chk(tc_pulse == 1'b0 && div_clk == 1'b0, "R1 async quiet", int'(tc_pulse), 0);
    repeat (3) @(negedge clk_ref);
    chk(tc_pulse == 1'b0 && div_clk == 1'b0, "R1 held quiet", int'(div_clk), 0);
    rst_n = 1'b1;
    n = 0;
    for (int i = 0; i < 400; i++) begin
      @(posedge clk_ref); #1;
      n++;
      if (tc_pulse) break;
    end
  endtask

  // from a strobe sample, count cycles to next strobe and div_clk high samples
  task automatic measure(output int n, output int hi, output int rise_ok, output int tc2);
    int prev;
    hi = div_clk ? 1 : 0;
    n = 0; tc2 = 0; prev = 0; rise_ok = 0;
    for (int i = 0; i < 400; i++) begin
      prev = int'(div_clk);
      @(posedge clk_ref); #1;
      n++;
      if (n == 1) tc2 = int'(tc_pulse);
      if (tc_pulse) begin
        rise_ok = (prev == 0 && div_clk == 1'b1) ? 1 : 0;
        break;
      end
      if (div_clk) hi++;
    end
  endtask

  task automatic to_tc(output int n);
    n = 0;
    for (int i = 0; i < 400; i++) begin
      @(posedge clk_ref); #1;
      n++;
      if (tc_pulse) break;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n, hi, rok, tc2, n2;
    rst_n = 1'b0;
    mod_code = 8'd4;
    #1;
    chk(tc_pulse == 1'b0 && div_clk == 1'b0, "R1 time-zero reset", int'(tc_pulse), 0);

    // table walk: R2 latency, R3/R4 period, R5 width, R6 duty and alignment
    for (int v = 0; v < NV; v++) begin
      reset_and_latency(V_CODE[v], n);
      chk(n == V_PER[v] + 3, "R2 first strobe latency", n, V_PER[v] + 3);
      chk(div_clk == 1'b1, "R6 div rises with first strobe", int'(div_clk), 1);
      measure(n, hi, rok, tc2);
      if (V_CODE[v] == 0) chk(n == 256, "R4 zero code period", n, 256);
      else                chk(n == V_PER[v], "R3 period", n, V_PER[v]);
      chk(tc2 == 0, "R5 strobe one cycle", tc2, 0);
      chk(hi == V_HI[v], "R6 high cycles", hi, V_HI[v]);
      chk(rok == 1, "R6 rise aligned with strobe", rok, 1);
      measure(n, hi, rok, tc2);
      chk(n == V_PER[v], "R3 second period", n, V_PER[v]);
    end

    // R7: ratio one passes reference through, strobe stuck high
    reset_and_latency(1, n);
    chk(n == 4, "R7 latency at ratio one (R2)", n, 4);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk_ref); #1;
      chk(tc_pulse == 1'b1, "R7 strobe high", int'(tc_pulse), 1);
      chk(div_clk == 1'b1, "R7 div follows clock high", int'(div_clk), 1);
      @(negedge clk_ref); #1;
      chk(div_clk == 1'b0, "R7 div follows clock low", int'(div_clk), 0);
      chk(tc_pulse == 1'b1, "R7 strobe high low-phase", int'(tc_pulse), 1);
    end

    // R8: mid-period code change deferred to next boundary
    reset_and_latency(10, n);
    repeat (3) begin @(posedge clk_ref); #1; end
    @(negedge clk_ref);
    mod_code = 8'd3;
    to_tc(n2);
    chk(n2 + 3 == 10, "R8 current period kept", n2 + 3, 10);
    to_tc(n);
    chk(n == 3, "R8 new ratio next period", n, 3);
    @(negedge clk_ref);
    mod_code = 8'd0;
    to_tc(n);
    to_tc(n);
    chk(n == 256, "R8 R4 switch to zero code", n, 256);

    // R1: reset asserted mid-run silences outputs without a clock edge
    @(posedge clk_ref); #1;
    rst_n = 1'b0;
    #1;
    chk(tc_pulse == 1'b0 && div_clk == 1'b0, "R1 mid-run reset", int'(div_clk), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk_ref);
    finish_run();
  end
endmodule